// File: doc/BRIEF.md
# Gate Scan and Frame Timing Generator

This block turns the internal oscillator clock of a 320-line panel driver into line and frame timing. A prescaler divides the oscillator by a power of two, and a line counter then counts a programmable number of divided ticks to form one line period. Each frame starts with blank back-porch lines. The active lines follow, and blank front-porch lines close the frame. The number of active lines is the programmed count plus one, and it never goes above 320.

For every active line the block works out which gate to select. The scan can run in linear order or in interlaced order, where the even gates come first and the odd gates follow. A direction input reverses either order. Two programmable screen windows pick which active lines are actually driven. An active line that falls outside both windows is still scanned, but it is flagged as non-display so that the output stage holds it at the minimum level. All outputs are decoded from the counter state and appear in the same cycle as that state.

Top module: `gate_scan_timer`

## Requirements
- R1: A line lasts (2^cfg_div)*(cfg_rtn+1) clock cycles. line_strobe is high on the first clock of every line and low on every other clock.
- R2: A frame lasts cfg_bp + A + cfg_fp lines, where A = min(cfg_lines,319)+1. With cfg_lines=319 and both porches set to 8, a frame is 336 lines long.
- R3: frame_start is high for exactly one clock, on the first clock of the first line of the frame. That line is the first back-porch line when cfg_bp>0.
- R4: On porch lines, gate_en and non_disp are 0 and gate_idx is 0.
- R5: With cfg_interlace=0 and cfg_reverse=0, active line k (0-based) selects gate k.
- R6: With cfg_interlace=1, active lines select the gates in the order 0,2,4,… and then 1,3,5,…. The even group has ceil(A/2) entries.
- R7: With cfg_reverse=1, the gate sequence of the selected order is produced back to front, so active line k uses the entry at position A-1-k.
- R8: An active line k drives its gate (gate_en=1) exactly when win0_start<=k<=win0_end or win1_start<=k<=win1_end. The bounds are inclusive.
- R9: An active line outside both windows gives non_disp=1 and gate_en=0, and gate_idx still carries its gate.
- R10: A window whose start is greater than its end contains no lines.
- R11: A cfg_lines value above 319 behaves exactly like 319.
- R12: While rst_n is low, and on the first clock after it is released, the block sits at the first clock of a frame, so line_strobe and frame_start are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lines | input | 9 | Active line count minus one |
| cfg_bp | input | 8 | Back-porch line count |
| cfg_fp | input | 8 | Front-porch line count |
| cfg_div | input | 2 | Prescaler exponent, ratio 2^cfg_div |
| cfg_rtn | input | 5 | Divided ticks per line minus one |
| cfg_interlace | input | 1 | Even gates first, then odd gates |
| cfg_reverse | input | 1 | Reverse the scan order |
| win0_start | input | 9 | First active line of window 0 |
| win0_end | input | 9 | Last active line of window 0 |
| win1_start | input | 9 | First active line of window 1 |
| win1_end | input | 9 | Last active line of window 1 |
| line_strobe | output | 1 | First clock of each line |
| frame_start | output | 1 | First clock of each frame |
| gate_idx | output | 9 | Selected gate on active lines |
| gate_en | output | 1 | Active line inside a window |
| non_disp | output | 1 | Active line outside both windows |

## Verification
Two things can happen in the same cycle here. A line boundary can coincide with the frame wrap, and the order mapping (interlace plus reverse) can land on the same line where a window edge starts or stops driving. The bench covers the first case with no porches and one-clock lines, so that frame_start, line_strobe and an active gate all appear on the same clock. It covers the second case by placing window edges on lines whose interlaced or reversed gate differs from the line number. A behavioural model computes every output from the clock count since reset and compares all of them on every clock. Any mismatch in timing or in gate choice is reported against the requirement it breaks.

// File: rtl/gate_scan_timer.sv
module gate_scan_timer #(
  parameter int LINES = 320,
  parameter int LW    = 9,
  parameter int PW    = 8,
  parameter int RW    = 5,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_lines,
  input  logic [PW-1:0] cfg_bp,
  input  logic [PW-1:0] cfg_fp,
  input  logic [DW-1:0] cfg_div,
  input  logic [RW-1:0] cfg_rtn,
  input  logic          cfg_interlace,
  input  logic          cfg_reverse,
  input  logic [LW-1:0] win0_start,
  input  logic [LW-1:0] win0_end,
  input  logic [LW-1:0] win1_start,
  input  logic [LW-1:0] win1_end,
  output logic          line_strobe,
  output logic          frame_start,
  output logic [LW-1:0] gate_idx,
  output logic          gate_en,
  output logic          non_disp
);
  localparam int DCW = (1 << DW) - 1;
  localparam int FW  = LW + 2;
  localparam logic [LW-1:0] MAXN = LW'(LINES - 1);

  logic [DCW-1:0] div_cnt;
  logic [RW-1:0]  tick_cnt;
  logic [FW-1:0]  fl;

  logic [DCW-1:0] div_lim;
  logic [LW-1:0]  n_cl, k, kk, half, g;
  logic [FW-1:0]  act_lo, act_hi, total;
  logic           active, in_win;

  assign div_lim = (DCW'(1) << cfg_div) - DCW'(1);
  assign n_cl    = (cfg_lines > MAXN) ? MAXN : cfg_lines;
  assign act_lo  = FW'(cfg_bp);
  assign act_hi  = act_lo + FW'(n_cl) + FW'(1);
  assign total   = act_hi + FW'(cfg_fp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
      fl       <= '0;
    end else if (div_cnt == div_lim) begin
      div_cnt <= '0;
      if (tick_cnt == cfg_rtn) begin
        tick_cnt <= '0;
        fl       <= (fl == total - FW'(1)) ? '0 : fl + FW'(1);
      end else begin
        tick_cnt <= tick_cnt + RW'(1);
      end
    end else begin
      div_cnt <= div_cnt + DCW'(1);
    end
  end

  assign line_strobe = (div_cnt == '0) && (tick_cnt == '0);
  assign frame_start = line_strobe && (fl == '0);

  assign active = (fl >= act_lo) && (fl < act_hi);
  assign k      = LW'(fl - act_lo);
  assign kk     = cfg_reverse ? (n_cl - k) : k;
  assign half   = LW'((FW'(n_cl) + FW'(2)) >> 1);

  always_comb begin
    if (!cfg_interlace)  g = kk;
    else if (kk < half)  g = LW'(kk << 1);
    else                 g = LW'(((kk - half) << 1) | LW'(1));
  end

  assign in_win = ((k >= win0_start) && (k <= win0_end)) ||
                  ((k >= win1_start) && (k <= win1_end));

  assign gate_idx = active ? g : '0;
  assign gate_en  = active && in_win;
  assign non_disp = active && !in_win;
endmodule

module gate_scan_timer_chk #(
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_strobe,
  input logic          frame_start,
  input logic [LW-1:0] gate_idx,
  input logic          gate_en,
  input logic          non_disp
);
  p_drive_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && non_disp));

  p_frame_on_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_strobe);

  p_gate_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en || non_disp) |-> (gate_idx < LW'(320)));

  p_porch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en || non_disp) |-> (gate_idx == '0));

  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !line_strobe) |-> $stable(gate_idx));
endmodule

bind gate_scan_timer gate_scan_timer_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
  .frame_start(frame_start), .gate_idx(gate_idx),
  .gate_en(gate_en), .non_disp(non_disp)
);

// File: tb/gate_scan_timer_tb.sv
module gate_scan_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] cfg_lines = 9'd319;
  logic [7:0] cfg_bp = 8'd8, cfg_fp = 8'd8;
  logic [1:0] cfg_div = 2'd0;
  logic [4:0] cfg_rtn = 5'd0;
  logic cfg_interlace = 1'b0, cfg_reverse = 1'b0;
  logic [8:0] win0_start = 9'd0, win0_end = 9'd319, win1_start = 9'd1, win1_end = 9'd0;
  logic line_strobe, frame_start, gate_en, non_disp;
  logic [8:0] gate_idx;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  gate_scan_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_lines(cfg_lines), .cfg_bp(cfg_bp), .cfg_fp(cfg_fp),
    .cfg_div(cfg_div), .cfg_rtn(cfg_rtn), .cfg_interlace(cfg_interlace),
    .cfg_reverse(cfg_reverse), .win0_start(win0_start), .win0_end(win0_end),
    .win1_start(win1_start), .win1_end(win1_end), .line_strobe(line_strobe),
    .frame_start(frame_start), .gate_idx(gate_idx), .gate_en(gate_en), .non_disp(non_disp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input int c, input string tag);
    int p, nact, tot, line, fl, k, kk, half, g, ls, act, inw;
    p    = (1 << cfg_div) * (int'(cfg_rtn) + 1);
    nact = ((int'(cfg_lines) > 319) ? 319 : int'(cfg_lines)) + 1;
    tot  = int'(cfg_bp) + nact + int'(cfg_fp);
    line = c / p;
    ls   = (c % p == 0) ? 1 : 0;
    fl   = line % tot;
    act  = (fl >= int'(cfg_bp) && fl < int'(cfg_bp) + nact) ? 1 : 0;
    k    = fl - int'(cfg_bp);
    kk   = cfg_reverse ? (nact - 1 - k) : k;
    half = (nact + 1) / 2;
    g    = !cfg_interlace ? kk : (kk < half ? 2 * kk : 2 * (kk - half) + 1);
    inw  = ((k >= int'(win0_start) && k <= int'(win0_end)) ||
            (k >= int'(win1_start) && k <= int'(win1_end))) ? 1 : 0;
    chk("R1 line_strobe", int'(line_strobe), ls);
    chk("R3 frame_start", int'(frame_start), (ls && fl == 0) ? 1 : 0);
    if (act == 0) begin
      chk("R4 porch gate_en", int'(gate_en), 0);
      chk("R4 porch non_disp", int'(non_disp), 0);
      chk("R4 porch gate_idx", int'(gate_idx), 0);
    end else begin
      chk({tag, " gate_idx"}, int'(gate_idx), g);
      chk({tag, " R8 gate_en"}, int'(gate_en), inw);
      chk({tag, " R9 non_disp"}, int'(non_disp), 1 - inw);
    end
  endtask

  task automatic run(input string tag, input int cycles);
    int last_fs = -1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R12 reset line_strobe", int'(line_strobe), 1);
    chk("R12 reset frame_start", int'(frame_start), 1);
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      compare(c, tag);
      if (frame_start) begin
        if (last_fs >= 0)
          chk("R2 frame length", c - last_fs,
              (1 << cfg_div) * (int'(cfg_rtn) + 1) *
              (int'(cfg_bp) + int'(cfg_fp) + ((int'(cfg_lines) > 319) ? 320 : int'(cfg_lines) + 1)));
        last_fs = c;
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R5 R2: default 336-line frame, linear order
    run("R5", 700);

    // R6: interlaced, divided clock
    cfg_interlace = 1'b1; cfg_div = 2'd1; cfg_rtn = 5'd2; cfg_bp = 8'd2; cfg_fp = 8'd3;
    run("R6", 2100);

    // R7: reversed linear, short panel
    cfg_interlace = 1'b0; cfg_reverse = 1'b1; cfg_lines = 9'd19;
    cfg_div = 2'd2; cfg_rtn = 5'd1; cfg_bp = 8'd1; cfg_fp = 8'd2;
    run("R7", 400);

    // R7 R6: reversed interlace with odd line count
    cfg_interlace = 1'b1; cfg_lines = 9'd20; cfg_div = 2'd1; cfg_rtn = 5'd0;
    cfg_bp = 8'd3; cfg_fp = 8'd1;
    win0_start = 9'd4; win0_end = 9'd9; win1_start = 9'd15; win1_end = 9'd15;
    run("R7", 150);

    // R8 R9: two windows, linear
    cfg_interlace = 1'b0; cfg_reverse = 1'b0; cfg_lines = 9'd39; cfg_div = 2'd0;
    cfg_bp = 8'd2; cfg_fp = 8'd2;
    win0_start = 9'd5; win0_end = 9'd10; win1_start = 9'd30; win1_end = 9'd33;
    run("R8", 200);

    // R10: inverted window is empty, single-line window
    win0_start = 9'd15; win0_end = 9'd4; win1_start = 9'd7; win1_end = 9'd7;
    run("R10", 200);

    // R11: oversized count clamps, no porches so frame wrap meets active line
    cfg_lines = 9'd400; cfg_bp = 8'd0; cfg_fp = 8'd0; cfg_interlace = 1'b1;
    win0_start = 9'd0; win0_end = 9'd159; win1_start = 9'd300; win1_end = 9'd400;
    run("R11", 700);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule